// File: doc/BRIEF.md
# Solver Scalar Inner-Product Unit

This block gathers the per-cell products that a grid engine streams out during one sweep of a stabilised bi-conjugate gradient iteration. It keeps them in four tagged running sums. On command it turns those sums into the three iteration scalars, alpha, zeta and beta, which go back to the grid. Each product arrives with a two-bit tag that selects its sum. A per-sum clear mask starts a new sweep. A start strobe with an operation code requests one scalar once all products of the sweep are in.

All arithmetic is signed two's-complement fixed point with `FRAC` fraction bits. The sums are `AW = DW + ACC_EXT` bits wide and wrap on overflow. One radix-2 restoring divider is shared by all three scalars. It produces a quotient magnitude of `QN = AW + FRAC` bits, one bit per cycle, so every division takes a fixed number of cycles. Beta needs two divisions and one multiply. The r0·r sum of the previous sweep is kept in its own register: clearing the r0·r sum copies its value there first. A zero denominator gives a zero result and raises the error flag.

Top module: `sip_scalar_unit`

## Requirements
- R1: While rst_ni is low and after reset, alpha_o, zeta_o and beta_o are 0 and done_o, busy_o and err_o are 0.
- R2: On a clock edge with prod_valid_i high, prod_i (sign-extended) is added to the sum picked by prod_tag_i. Tag 0 is r0·r, tag 1 is r0·Ap, tag 2 is t·At and tag 3 is At·At. Each sum wraps modulo 2^AW as a signed AW-bit value.
- R3: On a clock edge, clear_i bit k sets sum k to zero. Bit 0 first copies the r0·r sum into the previous-sum register. A clear takes priority over a product for the same sum in the same cycle, and that product is dropped.
- R4: Operation code 0 sets alpha_o to the r0·r sum divided by the r0·Ap sum. The quotient is q = sign·trunc(|n|·2^FRAC / |d|), with its magnitude clipped to 2^(SW-1)-1. With a nonzero denominator, done_o rises QN+1 cycles after the edge that samples start_i.
- R5: Operation code 1 sets zeta_o to the t·At sum divided by the At·At sum. It uses the same quotient rule and latency as R4.
- R6: Operation code 2 sets beta_o to floor(qa·qr / 2^FRAC), clipped to [-2^(SW-1), 2^(SW-1)-1]. Here qr is the r0·r sum divided by the previous-sum register, and qa is alpha_o divided by zeta_o, both by the R4 rule. With nonzero denominators, done_o rises 2·(QN+1) cycles after start.
- R7: If a division has a zero denominator, the scalar the operation writes becomes 0 and err_o is 1. For alpha and zeta, done_o then rises one cycle after start. An operation with nonzero denominators leaves err_o at 0.
- R8: start_i is ignored while busy_o is high, and operation code 3 is ignored. An operation changes only its own scalar.
- R9: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse with busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prod_valid_i | input | 1 | Product present this cycle |
| prod_tag_i | input | 2 | Sum selector for the product |
| prod_i | input | DW | Signed fixed-point product |
| clear_i | input | 4 | Per-sum clear mask |
| start_i | input | 1 | Start the selected operation |
| op_i | input | 2 | 0 alpha, 1 zeta, 2 beta, 3 none |
| alpha_o | output | SW | Alpha scalar |
| zeta_o | output | SW | Zeta scalar |
| beta_o | output | SW | Beta scalar |
| done_o | output | 1 | Operation complete pulse |
| busy_o | output | 1 | Operation in progress |
| err_o | output | 1 | Last operation hit a zero denominator |

## Verification
The hardest state to reach is a beta computation whose inputs are exactly known. It depends on the previous r0·r sum, which is only loaded as a side effect of a clear, and on the alpha and zeta values left by earlier operations. The bench mirrors every clear in its model and computes alpha and zeta first through long sweeps, so that each beta request starts from a known old sum and known operands. It reaches zero old sums by clearing twice in a row. Dropped products and starts issued while busy are driven on purpose, and their effect is seen only through later quotients.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int NUM_SUMS = 4;
  localparam int TAG_RR   = 0;
  localparam int TAG_RAP  = 1;
  localparam int TAG_TAT  = 2;
  localparam int TAG_ATAT = 3;

  typedef enum logic [1:0] {
    OP_ALPHA = 2'd0,
    OP_ZETA  = 2'd1,
    OP_BETA  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALPHA,
    ST_ZETA,
    ST_BETA_R,
    ST_BETA_S
  } st_e;
endpackage

// File: rtl/sip_accum.sv
module sip_accum #(
  parameter int NS = 4,
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int OLD_IDX = 0,
  localparam int TW = $clog2(NS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [TW-1:0]          tag_i,
  input  logic [DW-1:0]          data_i,
  input  logic [NS-1:0]          clear_i,
  output logic [NS-1:0][AW-1:0]  sum_o,
  output logic [AW-1:0]          old_o
);
  logic [AW-1:0] ext_w;
  assign ext_w = AW'($signed(data_i));

  for (genvar g = 0; g < NS; g++) begin : g_sum
    logic [AW-1:0] sum_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 sum_q <= '0;
      else if (clear_i[g])                         sum_q <= '0;
      else if (valid_i && (tag_i == TW'(g)))       sum_q <= sum_q + ext_w;
    end
    assign sum_o[g] = sum_q;
  end

  // previous sweep's sum survives its clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 old_o <= '0;
    else if (clear_i[OLD_IDX])   old_o <= sum_o[OLD_IDX];
  end
endmodule

// File: rtl/sip_divider.sv
module sip_divider #(
  parameter int NW   = 24,
  parameter int FRAC = 8,
  parameter int OW   = 16,
  localparam int QN  = NW + FRAC,
  localparam int CW  = $clog2(QN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [NW-1:0] den_i,
  output logic          done_o,
  output logic          dz_o,
  output logic [OW-1:0] quot_o
);
  localparam logic [QN-1:0] MAXP = QN'((64'd1 << (OW - 1)) - 64'd1);

  logic          busy_q, done_q, dz_q, neg_q;
  logic [CW-1:0] cnt_q;
  logic [NW:0]   rem_q;
  logic [QN-1:0] dvd_q;
  logic [NW-1:0] dmag_q;

  logic [NW-1:0] num_mag, den_mag;
  logic [NW:0]   shl, diff;
  logic          ge;

  assign num_mag = num_i[NW-1] ? (~num_i + 1'b1) : num_i;
  assign den_mag = den_i[NW-1] ? (~den_i + 1'b1) : den_i;
  assign shl     = {rem_q[NW-1:0], dvd_q[QN-1]};
  assign ge      = shl >= {1'b0, dmag_q};
  assign diff    = shl - {1'b0, dmag_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvd_q  <= '0;
      dmag_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        cnt_q  <= '0;
        dmag_q <= den_mag;
        neg_q  <= num_i[NW-1] ^ den_i[NW-1];
        if (den_i == '0) begin
          dvd_q  <= '0;
          dz_q   <= 1'b1;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          dvd_q  <= {num_mag, {FRAC{1'b0}}};
          dz_q   <= 1'b0;
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        rem_q <= ge ? diff : shl;
        dvd_q <= {dvd_q[QN-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(QN - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  logic [OW-1:0] mag_clip;
  assign mag_clip = (dvd_q > MAXP) ? MAXP[OW-1:0] : dvd_q[OW-1:0];
  assign quot_o   = dz_q ? '0 : (neg_q ? (~mag_clip + 1'b1) : mag_clip);
  assign done_o   = done_q;
  assign dz_o     = dz_q;
endmodule

// File: rtl/sip_scalar_unit.sv
module sip_scalar_unit
  import sip_pkg::*;
#(
  parameter int DW      = 16,
  parameter int ACC_EXT = 8,
  parameter int FRAC    = 8,
  parameter int SW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prod_valid_i,
  input  logic [1:0]    prod_tag_i,
  input  logic [DW-1:0] prod_i,
  input  logic [3:0]    clear_i,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  output logic [SW-1:0] alpha_o,
  output logic [SW-1:0] zeta_o,
  output logic [SW-1:0] beta_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          err_o
);
  localparam int AW = DW + ACC_EXT;
  localparam int PW = 2 * SW;
  localparam logic signed [PW-1:0] B_HI = PW'((64'sd1 <<< (SW - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] B_LO = -B_HI - 1;

  logic [NUM_SUMS-1:0][AW-1:0] sum_w;
  logic [AW-1:0]               rr_old_w;

  sip_accum #(.NS(NUM_SUMS), .DW(DW), .AW(AW), .OLD_IDX(TAG_RR)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (prod_valid_i),
    .tag_i   (prod_tag_i),
    .data_i  (prod_i),
    .clear_i (clear_i),
    .sum_o   (sum_w),
    .old_o   (rr_old_w)
  );

  st_e           st_q;
  logic          launch, div_start, div_done, div_dz;
  logic [AW-1:0] div_num, div_den;
  logic [SW-1:0] div_q;
  logic [SW-1:0] alpha_q, zeta_q, beta_q, qr_q;
  logic          rflag_q, done_q, err_q;

  assign launch    = (st_q == ST_IDLE) && start_i && (op_i != OP_NONE);
  assign div_start = launch || ((st_q == ST_BETA_R) && div_done);

  always_comb begin
    div_num = sum_w[TAG_RR];
    div_den = sum_w[TAG_RAP];
    if (st_q == ST_BETA_R) begin
      div_num = AW'($signed(alpha_q));
      div_den = AW'($signed(zeta_q));
    end else begin
      unique case (op_i)
        OP_ZETA: begin div_num = sum_w[TAG_TAT]; div_den = sum_w[TAG_ATAT]; end
        OP_BETA: begin div_num = sum_w[TAG_RR];  div_den = rr_old_w;        end
        default: ;
      endcase
    end
  end

  sip_divider #(.NW(AW), .FRAC(FRAC), .OW(SW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .dz_o    (div_dz),
    .quot_o  (div_q)
  );

  // beta = (alpha/zeta) * (rr_new/rr_old), rescaled and clipped
  logic signed [PW-1:0] bprod, bshift;
  logic [SW-1:0]        beta_clip;
  assign bprod  = $signed(div_q) * $signed(qr_q);
  assign bshift = bprod >>> FRAC;
  always_comb begin
    if (bshift > B_HI)      beta_clip = B_HI[SW-1:0];
    else if (bshift < B_LO) beta_clip = B_LO[SW-1:0];
    else                    beta_clip = bshift[SW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      alpha_q <= '0;
      zeta_q  <= '0;
      beta_q  <= '0;
      qr_q    <= '0;
      rflag_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (launch) begin
          unique case (op_i)
            OP_ALPHA: st_q <= ST_ALPHA;
            OP_ZETA:  st_q <= ST_ZETA;
            default:  st_q <= ST_BETA_R;
          endcase
        end
        ST_ALPHA: if (div_done) begin
          alpha_q <= div_q;
          err_q   <= div_dz;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        ST_ZETA: if (div_done) begin
          zeta_q <= div_q;
          err_q  <= div_dz;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_BETA_R: if (div_done) begin
          qr_q    <= div_q;
          rflag_q <= div_dz;
          st_q    <= ST_BETA_S;
        end
        ST_BETA_S: if (div_done) begin
          beta_q <= (rflag_q || div_dz) ? '0 : beta_clip;
          err_q  <= rflag_q || div_dz;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign alpha_o = alpha_q;
  assign zeta_o  = zeta_q;
  assign beta_o  = beta_q;
  assign done_o  = done_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign err_o   = err_q;
endmodule

// File: rtl/sip_checker.sv
module sip_checker #(
  parameter int AW = 24,
  parameter int SW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic [3:0]    clear_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [SW-1:0] alpha_o,
  input logic [SW-1:0] zeta_o,
  input logic [SW-1:0] beta_o,
  input logic [AW-1:0] acc_rr,
  input logic [AW-1:0] acc_atat,
  input logic [AW-1:0] rr_old
);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i != 2'd3) |=> busy_o);
  a_r8_none_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'd3) |=> !busy_o);
  a_r8_alpha_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(alpha_o));
  a_r8_zeta_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(zeta_o));
  a_r8_beta_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(beta_o));
  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o));
  a_r3_old_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i[0] |=> rr_old == $past(acc_rr));
  a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i[3] |=> acc_atat == '0);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && !err_o));
endmodule

bind sip_scalar_unit sip_checker #(.AW(AW), .SW(SW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .clear_i  (clear_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .alpha_o  (alpha_o),
  .zeta_o   (zeta_o),
  .beta_o   (beta_o),
  .acc_rr   (sum_w[0]),
  .acc_atat (sum_w[3]),
  .rr_old   (rr_old_w)
);

// File: tb/tb_sip_scalar_unit.sv
`timescale 1ns/1ps
module tb_sip_scalar_unit;
  localparam int DW = 8, ACC_EXT = 4, FRAC = 4, SW = 12;
  localparam int AW = DW + ACC_EXT;
  localparam int QN = AW + FRAC;
  localparam longint MAXP = (longint'(1) << (SW - 1)) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic prod_valid_i = 1'b0, start_i = 1'b0;
  logic [1:0] prod_tag_i = '0, op_i = '0;
  logic [DW-1:0] prod_i = '0;
  logic [3:0] clear_i = '0;
  logic [SW-1:0] alpha_o, zeta_o, beta_o;
  logic done_o, busy_o, err_o;

  sip_scalar_unit #(.DW(DW), .ACC_EXT(ACC_EXT), .FRAC(FRAC), .SW(SW)) dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int unsigned seed = 32'h1234_5678;
  longint m_sum[4];
  longint m_old = 0, m_alpha = 0, m_zeta = 0, m_beta = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint wrap(input longint v);
    longint m = longint'(1) << AW;
    longint r = v % m;
    if (r < 0) r += m;
    if (r >= m / 2) r -= m;
    return r;
  endfunction

  function automatic longint div_model(input longint n, input longint d);
    longint an, ad, q;
    if (d == 0) return 0;
    an = n < 0 ? -n : n;
    ad = d < 0 ? -d : d;
    q = (an << FRAC) / ad;
    if (q > MAXP) q = MAXP;
    return ((n < 0) != (d < 0)) ? -q : q;
  endfunction

  function automatic int rnd_prod();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff) - 128;
  endfunction

  task automatic push(input int tag, input int val);
    @(negedge clk_i);
    prod_valid_i = 1'b1;
    prod_tag_i = 2'(tag);
    prod_i = DW'(val);
    m_sum[tag] = wrap(m_sum[tag] + val);
  endtask

  task automatic end_push();
    @(negedge clk_i);
    prod_valid_i = 1'b0;
  endtask

  task automatic clr(input logic [3:0] mask);
    @(negedge clk_i);
    prod_valid_i = 1'b0;
    clear_i = mask;
    if (mask[0]) m_old = m_sum[0];
    for (int k = 0; k < 4; k++) if (mask[k]) m_sum[k] = 0;
    @(negedge clk_i);
    clear_i = '0;
  endtask

  task automatic run_op(input logic [1:0] op, input string req, input int exp_lat, input logic exp_err);
    int lat;
    @(negedge clk_i);
    start_i = 1'b1;
    op_i = op;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk_i);
      lat++;
    end
    if (exp_lat >= 0) chk(req, "latency", lat, exp_lat);
    chk(req, "err_o", err_o, exp_err);
    chk(req, "alpha_o", longint'($signed(alpha_o)), m_alpha);
    chk(req, "zeta_o", longint'($signed(zeta_o)), m_zeta);
    chk(req, "beta_o", longint'($signed(beta_o)), m_beta);
    @(negedge clk_i);
    chk("R9", "done_o pulse", done_o, 0);
  endtask

  task automatic do_alpha(input string req);
    logic e = (m_sum[1] == 0);
    m_alpha = div_model(m_sum[0], m_sum[1]);
    run_op(2'd0, req, e ? 1 : QN + 1, e);
  endtask

  task automatic do_zeta(input string req);
    logic e = (m_sum[3] == 0);
    m_zeta = div_model(m_sum[2], m_sum[3]);
    run_op(2'd1, req, e ? 1 : QN + 1, e);
  endtask

  task automatic do_beta(input string req);
    logic e = (m_old == 0) || (m_zeta == 0);
    longint p;
    if (e) m_beta = 0;
    else begin
      p = (div_model(m_alpha, m_zeta) * div_model(m_sum[0], m_old)) >>> FRAC;
      if (p > MAXP) p = MAXP;
      if (p < -MAXP - 1) p = -MAXP - 1;
      m_beta = p;
    end
    run_op(2'd2, req, e ? -1 : 2 * (QN + 1), e);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_sum[k] = 0;
    #23;
    chk("R1", "alpha in reset", alpha_o, 0);
    chk("R1", "busy in reset", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "alpha", alpha_o, 0);
    chk("R1", "zeta", zeta_o, 0);
    chk("R1", "beta", beta_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "err", err_o, 0);

    // R2/R4: unit denominator exposes the r0.r sum directly
    clr(4'b0011);
    for (int j = 0; j < 5; j++) push(0, rnd_prod() / 4);
    push(1, 16);
    end_push();
    do_alpha("R2");

    // R4 / R7: alpha sweep, including empty denominator
    for (int i = 0; i < 12; i++) begin
      clr(4'b0011);
      for (int j = 0; j < 2 + (i % 6); j++) begin
        if (i == 3) push(0, rnd_prod());
        else push(int'(seed[20]), rnd_prod());
      end
      if (i != 3) push(1, rnd_prod() | 1);
      end_push();
      do_alpha(i == 3 ? "R7" : "R4");
    end

    // R5 / R7: zeta sweep
    for (int i = 0; i < 12; i++) begin
      clr(4'b1100);
      for (int j = 0; j < 2 + (i % 5); j++) begin
        if (i == 4) push(2, rnd_prod());
        else push(2 + int'(seed[19]), rnd_prod());
      end
      if (i != 4) push(3, rnd_prod() | 1);
      end_push();
      do_zeta(i == 4 ? "R7" : "R5");
    end
    clr(4'b1100);
    push(2, 40); push(3, 25); push(3, 7);
    end_push();
    do_zeta("R5");

    // R4 saturation both signs
    clr(4'b0011);
    for (int j = 0; j < 10; j++) push(0, 127);
    push(1, 1);
    end_push();
    do_alpha("R4");
    clr(4'b0011);
    for (int j = 0; j < 10; j++) push(0, -128);
    push(1, 2);
    end_push();
    do_alpha("R4");
    clr(4'b0011);
    push(0, 100); push(1, -30); push(0, 7);
    end_push();
    do_alpha("R4");

    // R6 / R3: beta sweep, old sum captured by clear
    for (int i = 0; i < 10; i++) begin
      if (i == 2) clr(4'b0001);
      clr(4'b0001);
      for (int j = 0; j < 1 + (i % 4); j++) push(0, rnd_prod() / 2);
      end_push();
      do_beta(i == 2 ? "R7" : "R6");
    end
    // beta with zero zeta
    clr(4'b1100);
    end_push();
    do_zeta("R7");
    clr(4'b0001);
    push(0, 33);
    end_push();
    do_beta("R7");

    // R3: clear beats a same-cycle product
    @(negedge clk_i);
    clear_i = 4'b1100;
    prod_valid_i = 1'b1; prod_tag_i = 2'd2; prod_i = DW'(50);
    m_sum[2] = 0; m_sum[3] = 0;
    @(negedge clk_i);
    clear_i = '0; prod_valid_i = 1'b0;
    push(2, 3); push(3, 16);
    end_push();
    do_zeta("R3");

    // R8: start while busy is ignored
    clr(4'b0011);
    push(0, 20); push(1, 9);
    end_push();
    m_alpha = div_model(m_sum[0], m_sum[1]);
    @(negedge clk_i); start_i = 1'b1; op_i = 2'd0;
    @(negedge clk_i); start_i = 1'b1; op_i = 2'd1;
    chk("R9", "busy after start", busy_o, 1);
    @(negedge clk_i); start_i = 1'b0;
    begin
      int lat = 1;
      while (!done_o && lat < 200) begin @(negedge clk_i); lat++; end
      chk("R8", "latency with ignored start", lat, QN + 1);
    end
    chk("R8", "alpha", longint'($signed(alpha_o)), m_alpha);
    chk("R8", "zeta untouched", longint'($signed(zeta_o)), m_zeta);
    @(negedge clk_i);
    chk("R8", "no second done", done_o, 0);
    chk("R8", "idle after", busy_o, 0);

    // R8: op code 3 ignored
    @(negedge clk_i); start_i = 1'b1; op_i = 2'd3;
    @(negedge clk_i); start_i = 1'b0;
    chk("R8", "op3 busy", busy_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R8", "op3 done", done_o, 0);
    chk("R8", "op3 alpha", longint'($signed(alpha_o)), m_alpha);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule